// File: doc/BRIEF.md
# GPIO Port Register File With Aliased Pin Views

This block is the register file behind a single 32-pin general-purpose I/O port. It sits on a simple bus that carries byte addresses and 32-bit data. It holds three state vectors: the output levels, the pin directions and an access mask. It drives the output-level and output-enable vectors to the pads and samples the pad input vector through a two-stage synchroniser.

Software can reach the same pin through several aliases. There is one byte register per pin and one word register per pin. There is a raw whole-port register that ignores the mask, and a masked whole-port register that only touches enabled bits. Write-one-to-act registers set, clear or flip output levels and direction bits without a read-modify-write. The value read back for a pin is its driven level when the pin is an output, and its synchronised input when it is an input.

Reads return their data one cycle after the request, qualified by a valid strobe. Writes take effect at the clock edge that samples them.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction, output and mask vectors are all zero. `pin_oe` and `pin_out` are therefore 0, and every bit of the masked view is enabled.
- R2: A write to offset 0x2000 loads the direction vector, and a read returns it whole. A direction bit of 1 makes the pin an output and drives its `pin_oe` bit high.
- R3: Writes to 0x2200 (set), 0x2280 (clear) and 0x2300 (toggle) change only the output bits written as 1. A read of 0x2200 returns the output vector.
- R4: Writes to 0x2380 (set), 0x2400 (clear) and 0x2480 (toggle) change only the direction bits written as 1. Reads of 0x2280, 0x2300, 0x2380, 0x2400 and 0x2480 return 0.
- R5: A write to 0x2100 loads all 32 output bits whatever the mask. A read of 0x2100 returns every pin state, ignoring the mask.
- R6: The state of a pin is its output bit when its direction bit is 1. Otherwise it is its input, seen after two clock edges of synchronisation.
- R7: The mask register at 0x2080 reads back as written. A write to 0x2180 updates only the output bits whose mask bit is 0.
- R8: A read of 0x2180 returns the pin states with every bit whose mask bit is 1 forced to 0.
- R9: The byte register of pin n is at offset n. A write with a nonzero low byte drives the pin's output bit to 1, and a zero low byte drives it to 0. A read returns 0 or 1.
- R10: The word register of pin n is at offset 0x1000 + 4n. Any nonzero write drives the output bit to 1, and zero drives it to 0. A read returns 0xFFFFFFFF when the pin state is 1 and 0 otherwise.
- R11: Reads of unmapped or misaligned offsets return 0, and writes to them leave every state vector unchanged.
- R12: A read request sampled at a clock edge sets `bus_rvalid` with its data after that edge, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 14 | Byte offset from the block base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after the request |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Output level vector |
| pin_oe | output | 32 | Output enable vector, equal to the direction bits |

## Verification
The assertions assume that a request is held for one cycle, and that `bus_we` and `bus_addr` are stable while `bus_sel` is high. They also take `pin_in` as asynchronous, so no assertion relates it to the read path at a fixed cycle. The bench drives every request for exactly one cycle, from the falling edge. It changes `pin_in` only while idle, and waits three cycles before reading a pin state, so the synchroniser has settled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_BYTE, RG_WORD, RG_DIR, RG_MASK, RG_PIN, RG_MPIN,
    RG_OSET, RG_OCLR, RG_OTOG, RG_DSET, RG_DCLR, RG_DTOG
  } region_e;

  // Whole-port registers sit in 128-byte slots; slot = offset >> 7.
  localparam logic [31:0] SLOT_DIR  = 32'h40;
  localparam logic [31:0] SLOT_MASK = 32'h41;
  localparam logic [31:0] SLOT_PIN  = 32'h42;
  localparam logic [31:0] SLOT_MPIN = 32'h43;
  localparam logic [31:0] SLOT_OSET = 32'h44;
  localparam logic [31:0] SLOT_OCLR = 32'h45;
  localparam logic [31:0] SLOT_OTOG = 32'h46;
  localparam logic [31:0] SLOT_DSET = 32'h47;
  localparam logic [31:0] SLOT_DCLR = 32'h48;
  localparam logic [31:0] SLOT_DTOG = 32'h49;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PIN_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PIN_W-1:0]  pin_idx
);

  localparam int SLOT_W = ADDR_W - 7;

  logic [31:0] slot;
  logic        byte_hit;
  logic        word_hit;

  always_comb begin
    slot     = {{(32-SLOT_W){1'b0}}, addr[ADDR_W-1:7]};
    byte_hit = (addr[ADDR_W-1:PIN_W] == '0);
    word_hit = (addr[ADDR_W-1:12] == (ADDR_W-12)'(1)) &&
               (addr[11:PIN_W+2] == '0) && (addr[1:0] == 2'b00);
    pin_idx  = byte_hit ? addr[PIN_W-1:0] : addr[PIN_W+1:2];
    region   = RG_NONE;
    if (byte_hit) begin
      region = RG_BYTE;
    end else if (word_hit) begin
      region = RG_WORD;
    end else if (addr[6:0] == 7'd0) begin
      unique case (slot)
        SLOT_DIR:  region = RG_DIR;
        SLOT_MASK: region = RG_MASK;
        SLOT_PIN:  region = RG_PIN;
        SLOT_MPIN: region = RG_MPIN;
        SLOT_OSET: region = RG_OSET;
        SLOT_OCLR: region = RG_OCLR;
        SLOT_OTOG: region = RG_OTOG;
        SLOT_DSET: region = RG_DSET;
        SLOT_DCLR: region = RG_DCLR;
        SLOT_DTOG: region = RG_DTOG;
        default:   region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_state_regs.sv
module gpio_state_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  region_e          region,
  input  logic [PIN_W-1:0] pin_idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q
);

  logic [WIDTH-1:0] out_n, dir_n, mask_n;

  always_comb begin
    out_n  = out_q;
    dir_n  = dir_q;
    mask_n = mask_q;
    unique case (region)
      RG_BYTE: out_n[pin_idx] = (wdata[7:0] != 8'd0);
      RG_WORD: out_n[pin_idx] = (wdata != '0);
      RG_DIR:  dir_n  = wdata;
      RG_MASK: mask_n = wdata;
      RG_PIN:  out_n  = wdata;
      RG_MPIN: out_n  = (out_q & mask_q) | (wdata & ~mask_q);
      RG_OSET: out_n  = out_q | wdata;
      RG_OCLR: out_n  = out_q & ~wdata;
      RG_OTOG: out_n  = out_q ^ wdata;
      RG_DSET: dir_n  = dir_q | wdata;
      RG_DCLR: dir_n  = dir_q & ~wdata;
      RG_DTOG: dir_n  = dir_q ^ wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      out_q  <= out_n;
      dir_q  <= dir_n;
      mask_q <= mask_n;
    end
  end

  assert_oset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_OSET) |=> ((out_q & $past(wdata)) == $past(wdata)));
  assert_oclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_OCLR) |=> ((out_q & $past(wdata)) == '0));
  assert_dset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_DSET) |=> (((dir_q ^ $past(dir_q)) & ~$past(wdata)) == '0));
  assert_mpin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_MPIN) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || region == RG_NONE) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);

  localparam int PIN_W = $clog2(DATA_W);

  region_e           region;
  logic [PIN_W-1:0]  pin_idx;
  logic [DATA_W-1:0] in_sync, out_q, dir_q, mask_q, pin_state;
  logic [DATA_W-1:0] rdata_n;
  logic              rd_req, wr_req;

  assign rd_req = bus_sel && !bus_we;
  assign wr_req = bus_sel && bus_we;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_dec (
    .addr(bus_addr), .region(region), .pin_idx(pin_idx)
  );

  gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync)
  );

  gpio_state_regs #(.WIDTH(DATA_W), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req), .region(region),
    .pin_idx(pin_idx), .wdata(bus_wdata),
    .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q)
  );

  assign pin_state = (dir_q & out_q) | (~dir_q & in_sync);
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

  always_comb begin
    unique case (region)
      RG_BYTE: rdata_n = {{(DATA_W-1){1'b0}}, pin_state[pin_idx]};
      RG_WORD: rdata_n = {DATA_W{pin_state[pin_idx]}};
      RG_DIR:  rdata_n = dir_q;
      RG_MASK: rdata_n = mask_q;
      RG_PIN:  rdata_n = pin_state;
      RG_MPIN: rdata_n = pin_state & ~mask_q;
      RG_OSET: rdata_n = out_q;
      default: rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rdata_n;
    end
  end

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  assert_rvalid_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RG_NONE) |=> (bus_rdata == '0));
  assert_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && region == RG_DIR) |=> (pin_oe == $past(bus_wdata)));

endmodule

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_out = '0, m_dir = '0, m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] state_v();
    return (m_dir & m_out) | (~m_dir & pin_in);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard whenever the design returns read data.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [13:0] a, logic [31:0] d);
    logic [31:0] s;
    s = state_v();
    case (a)
      14'h2000: m_dir = d;
      14'h2080: m_mask = d;
      14'h2100: m_out = d;
      14'h2180: m_out = (m_out & m_mask) | (d & ~m_mask);
      14'h2200: m_out = m_out | d;
      14'h2280: m_out = m_out & ~d;
      14'h2300: m_out = m_out ^ d;
      14'h2380: m_dir = m_dir | d;
      14'h2400: m_dir = m_dir & ~d;
      14'h2480: m_dir = m_dir ^ d;
      default: begin
        if (a < 14'h20) m_out[a[4:0]] = (d[7:0] != 0);
        else if (a >= 14'h1000 && a < 14'h1080 && a[1:0] == 0) m_out[a[6:2]] = (d != 0);
      end
    endcase
    if (s === 32'hx) m_out = m_out;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [13:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    idle(WATCHDOG);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 pin_out after reset", pin_out, 32'h0);
    check("R1 pin_oe after reset", pin_oe, 32'h0);
    check("R12 rvalid idle", {31'b0, bus_rvalid}, 32'h0);
    rd(14'h2000, 32'h0, "R1 dir reset");
    rd(14'h2080, 32'h0, "R1 mask reset");
    rd(14'h2200, 32'h0, "R1 out reset");
    // R2: direction load
    wr(14'h2000, 32'h0000FFFF);
    rd(14'h2000, m_dir, "R2 dir readback");
    check("R2 pin_oe", pin_oe, 32'h0000FFFF);
    // R3: output set/clear/toggle
    wr(14'h2200, 32'h0F0F0F0F);
    rd(14'h2200, m_out, "R3 after set");
    wr(14'h2280, 32'h00000F0F);
    wr(14'h2300, 32'hFF000001);
    rd(14'h2200, m_out, "R3 after clear+toggle");
    check("R3 pin_out", pin_out, 32'hF00F0001);
    // R4: direction modify and write-only reads
    wr(14'h2380, 32'h00FF0000);
    wr(14'h2400, 32'h0000000F);
    wr(14'h2480, 32'h80000001);
    rd(14'h2000, m_dir, "R4 dir after modify");
    check("R4 pin_oe", pin_oe, 32'h80FFFFF1);
    rd(14'h2280, 32'h0, "R4 oclr reads 0");
    rd(14'h2300, 32'h0, "R4 otog reads 0");
    rd(14'h2380, 32'h0, "R4 dset reads 0");
    rd(14'h2400, 32'h0, "R4 dclr reads 0");
    rd(14'h2480, 32'h0, "R4 dtog reads 0");
    // R6/R5: pin state mixes outputs and synchronised inputs
    pin_in = 32'hA5A55A5A;
    idle(3);
    rd(14'h2100, state_v(), "R6 pin state mix");
    wr(14'h2080, 32'hFFFF0000);
    rd(14'h2080, 32'hFFFF0000, "R7 mask readback");
    wr(14'h2100, 32'h12345678);
    rd(14'h2200, 32'h12345678, "R5 raw write ignores mask");
    rd(14'h2100, state_v(), "R5 raw read ignores mask");
    // R7/R8: masked access
    wr(14'h2180, 32'hFFFFFFFF);
    rd(14'h2200, 32'h1234FFFF, "R7 masked write");
    rd(14'h2180, state_v() & ~m_mask, "R8 masked read");
    wr(14'h2080, 32'h0);
    wr(14'h2000, 32'hFFFFFFFF);
    rd(14'h2180, m_out, "R8 masked read all enabled");
    // R9: byte registers
    wr(14'h2000, 32'h0000FFFF);
    wr(14'h0003, 32'h00000080);
    rd(14'h0003, 32'h1, "R9 byte pin3 high");
    wr(14'h0003, 32'hFFFFFF00);
    rd(14'h0003, 32'h0, "R9 byte pin3 low");
    rd(14'h0014, {31'b0, pin_in[20]}, "R9 byte pin20 input");
    // R10: word registers
    wr(14'h101C, 32'h00000010);
    rd(14'h101C, 32'hFFFFFFFF, "R10 word pin7 high");
    wr(14'h101C, 32'h0);
    rd(14'h101C, 32'h0, "R10 word pin7 low");
    rd(14'h107C, {32{pin_in[31]}}, "R10 word pin31 input");
    // R11: unmapped offsets
    wr(14'h2500, 32'hFFFFFFFF);
    wr(14'h0020, 32'hFFFFFFFF);
    wr(14'h2082, 32'hFFFFFFFF);
    wr(14'h101E, 32'hFFFFFFFF);
    check("R11 pin_out unchanged", pin_out, m_out);
    check("R11 pin_oe unchanged", pin_oe, m_dir);
    rd(14'h2080, 32'h0, "R11 mask unchanged");
    rd(14'h2504, 32'h0, "R11 unmapped read");
    rd(14'h2084, 32'h0, "R11 misaligned read");
    rd(14'h0FFC, 32'h0, "R11 gap read");
    idle(3);
    check("R12 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule